// File: doc/BRIEF.md
# Receive Character Queue with Channel Status

This block sits between a serial receive deserializer and the processor read path of an asynchronous serial channel. Each time the deserializer finishes a character, it presents the data byte, a missing-stop-bit indication and a parity bit. The block stores these in a three-deep circular queue. When the queue is full, one more character can park in an overflow slot that stands for the receive shift register. The processor sees the oldest stored character on the read data port, together with that character's own break, framing and parity flags. A read strobe pops that character.

Several status bits are derived from the queue. One says that characters are waiting, one says the queue is full, and one is a sticky overrun bit that only a clear-error command resets. A break is a character that is all zeros and has no stop bit. The block stores it as a single entry and then refuses further characters until the sampler reports that the line has been idle (marking) for half a bit time. Both the start and the end of a break raise a one-cycle change-in-break pulse.

Top module: `rxq_status`

## Requirements
- R1: After synchronous reset the queue is empty and the parking slot is free. Every status output, every flag output, rd_data and irq_brk_chg are 0.
- R2: Characters are read out in arrival order. rd_data always shows the oldest stored character, and an edge with cpu_rd high removes it. The queue holds DEPTH=3 characters.
- R3: stat_rxrdy is 1 exactly when the queue holds at least one character. A read clears it only when that read empties the queue.
- R4: stat_ffull is 1 exactly when all three queue positions are occupied. A read while a character is parked leaves it at 1.
- R5: A character that arrives while the queue is full is parked. On the next read it moves into the queue in that same cycle, behind the existing entries.
- R6: A character that arrives while the queue is full and the slot is already occupied sets stat_ovr. The parked character and its flags are lost, and the new character takes the slot.
- R7: stat_ovr stays 1 until an edge with cmd_clr_err high. If an overrun happens on the same edge as the clear, stat_ovr stays at 1.
- R8: stat_frm and stat_par show the framing flag (rx_frm_err) and the parity/address bit (rx_par_bit) that arrived with the oldest stored character. All flag outputs and rd_data are 0 while the queue is empty.
- R9: A character with all data bits 0 and rx_frm_err=1 is a break. It is stored once with stat_brk=1 (and stat_frm=1). All later characters are dropped until rx_line_idle is seen. rx_line_idle has no effect outside a break. An all-zero character with rx_frm_err=0 is an ordinary character.
- R10: irq_brk_chg is high for exactly one cycle after the edge that accepts a break character, and for one cycle after the edge at which rx_line_idle ends a break. At all other times it is 0.
- R11: A read strobe while the queue is empty has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a completed character is present |
| rx_data | input | DATA_W | Received character bits |
| rx_frm_err | input | 1 | Stop bit was sampled low at its middle |
| rx_par_bit | input | 1 | Parity error, or address/data bit in multidrop mode |
| rx_line_idle | input | 1 | Line has been marking for at least half a bit time |
| cpu_rd | input | 1 | Processor read strobe: pop the oldest character |
| cmd_clr_err | input | 1 | Clear-error command: resets the overrun bit |
| rd_data | output | DATA_W | Oldest stored character, 0 when empty |
| stat_rxrdy | output | 1 | Queue not empty |
| stat_ffull | output | 1 | All queue positions occupied |
| stat_ovr | output | 1 | Sticky overrun |
| stat_brk | output | 1 | Oldest character is a break |
| stat_frm | output | 1 | Oldest character had a framing error |
| stat_par | output | 1 | Parity/address bit of oldest character |
| irq_brk_chg | output | 1 | One-cycle change-in-break pulse |

## Verification
Most internal faults show up at the ports within one or two cycles. A wrong occupancy count shows as a stat_rxrdy or stat_ffull mismatch on the very next cycle. A misrouted parked character shows as out-of-order rd_data or a dropped stat_ffull on the read that should have moved it in. A stuck break state shows as lost characters after the idle pulse, and as a missing second irq_brk_chg. The reference model is compared with every output on every cycle, so a divergence is reported in the cycle it first appears, not when the queue is next drained.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Per-character flags, stored alongside every queue entry.
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rxq_flags_t;

    localparam rxq_flags_t RXQ_FLAGS_NONE = '{brk: 1'b0, frm: 1'b0, par: 1'b0};

    // Where an arriving character goes in the current cycle.
    typedef enum logic [1:0] {
        RXQ_ROUTE_NONE    = 2'd0,
        RXQ_ROUTE_DIRECT  = 2'd1,
        RXQ_ROUTE_PARK    = 2'd2,
        RXQ_ROUTE_CLOBBER = 2'd3
    } rxq_route_e;

    // Circular pointer step for a depth that need not be a power of two.
    function automatic int unsigned rxq_wrap_inc(input int unsigned ptr,
                                                 input int unsigned depth);
        return (ptr + 1 >= depth) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 3,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [DATA_W-1:0]             wr_data,
    input  rxq_flags_t                    wr_flags,
    input  logic                          rd_en,
    output logic [DATA_W-1:0]             head_data,
    output rxq_flags_t                    head_flags,
    output logic [$clog2(DEPTH+1)-1:0]    count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem_data  [DEPTH];
    rxq_flags_t        mem_flags [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    // One register slot per entry, written when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_data[g]  <= '0;
                mem_flags[g] <= RXQ_FLAGS_NONE;
            end else if (wr_en && (wr_ptr == PTR_W'(g))) begin
                mem_data[g]  <= wr_data;
                mem_flags[g] <= wr_flags;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= PTR_W'(rxq_wrap_inc(int'(wr_ptr), DEPTH));
            end
            if (rd_en) begin
                rd_ptr <= PTR_W'(rxq_wrap_inc(int'(rd_ptr), DEPTH));
            end
            count <= count + CNT_W'(wr_en) - CNT_W'(rd_en);
        end
    end

    assign head_data  = mem_data[rd_ptr];
    assign head_flags = mem_flags[rd_ptr];

endmodule

// File: rtl/rxq_hold_slot.sv
module rxq_hold_slot
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 3,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [DATA_W-1:0]             in_data,
    input  rxq_flags_t                    in_flags,
    input  logic [$clog2(DEPTH+1)-1:0]    fifo_count,
    input  logic                          fifo_pop,
    input  logic                          clr_err,
    output logic                          wr_en,
    output logic [DATA_W-1:0]             wr_data,
    output rxq_flags_t                    wr_flags,
    output logic                          hold_valid,
    output logic                          overrun
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] hold_data;
    rxq_flags_t        hold_flags;
    logic [CNT_W-1:0]  count_after_pop;
    logic              room;
    logic              hold_moves;
    rxq_route_e        route;

    assign count_after_pop = fifo_count - CNT_W'(fifo_pop);
    assign room            = (count_after_pop < CNT_W'(DEPTH));
    assign hold_moves      = hold_valid && room;

    always_comb begin
        route = RXQ_ROUTE_NONE;
        if (in_valid) begin
            if (hold_valid && !hold_moves) begin
                route = RXQ_ROUTE_CLOBBER;
            end else if (!hold_valid && room) begin
                route = RXQ_ROUTE_DIRECT;
            end else begin
                route = RXQ_ROUTE_PARK;
            end
        end
    end

    // Single queue write port: the parked character has priority.
    always_comb begin
        wr_en    = 1'b0;
        wr_data  = in_data;
        wr_flags = in_flags;
        if (hold_moves) begin
            wr_en    = 1'b1;
            wr_data  = hold_data;
            wr_flags = hold_flags;
        end else if (route == RXQ_ROUTE_DIRECT) begin
            wr_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
            hold_flags <= RXQ_FLAGS_NONE;
            overrun    <= 1'b0;
        end else begin
            case (route)
                RXQ_ROUTE_PARK, RXQ_ROUTE_CLOBBER: begin
                    hold_valid <= 1'b1;
                    hold_data  <= in_data;
                    hold_flags <= in_flags;
                end
                default: begin
                    if (hold_moves) begin
                        hold_valid <= 1'b0;
                    end
                end
            endcase
            overrun <= (route == RXQ_ROUTE_CLOBBER) || (overrun && !clr_err);
        end
    end

endmodule

// File: rtl/rxq_break_seq.sv
module rxq_break_seq (
    input  logic clk,
    input  logic rst,
    input  logic char_valid,
    input  logic char_is_brk,
    input  logic line_idle,
    output logic char_accept,
    output logic in_brk,
    output logic brk_chg
);
    logic brk_start;
    logic brk_end;

    assign char_accept = char_valid && !in_brk;
    assign brk_start   = char_accept && char_is_brk;
    assign brk_end     = in_brk && line_idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_brk  <= 1'b0;
            brk_chg <= 1'b0;
        end else begin
            brk_chg <= brk_start || brk_end;
            if (brk_end) begin
                in_brk <= 1'b0;
            end else if (brk_start) begin
                in_brk <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_frm_err,
    input  logic              rx_par_bit,
    input  logic              rx_line_idle,
    input  logic              cpu_rd,
    input  logic              cmd_clr_err,
    output logic [DATA_W-1:0] rd_data,
    output logic              stat_rxrdy,
    output logic              stat_ffull,
    output logic              stat_ovr,
    output logic              stat_brk,
    output logic              stat_frm,
    output logic              stat_par,
    output logic              irq_brk_chg
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              is_brk_char;
    logic              char_accept;
    logic              in_brk;
    rxq_flags_t        new_flags;
    logic              fifo_wr;
    logic [DATA_W-1:0] fifo_wr_data;
    rxq_flags_t        fifo_wr_flags;
    logic              fifo_rd;
    logic [DATA_W-1:0] head_data;
    rxq_flags_t        head_flags;
    logic [CNT_W-1:0]  fifo_count;
    logic              hold_valid;

    assign is_brk_char = rx_frm_err && (rx_data == '0);
    assign new_flags   = '{brk: is_brk_char, frm: rx_frm_err, par: rx_par_bit};
    assign fifo_rd     = cpu_rd && (fifo_count != '0);

    rxq_break_seq u_brk (
        .clk         (clk),
        .rst         (rst),
        .char_valid  (rx_valid),
        .char_is_brk (is_brk_char),
        .line_idle   (rx_line_idle),
        .char_accept (char_accept),
        .in_brk      (in_brk),
        .brk_chg     (irq_brk_chg)
    );

    rxq_hold_slot #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (char_accept),
        .in_data    (rx_data),
        .in_flags   (new_flags),
        .fifo_count (fifo_count),
        .fifo_pop   (fifo_rd),
        .clr_err    (cmd_clr_err),
        .wr_en      (fifo_wr),
        .wr_data    (fifo_wr_data),
        .wr_flags   (fifo_wr_flags),
        .hold_valid (hold_valid),
        .overrun    (stat_ovr)
    );

    rxq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (fifo_wr),
        .wr_data    (fifo_wr_data),
        .wr_flags   (fifo_wr_flags),
        .rd_en      (fifo_rd),
        .head_data  (head_data),
        .head_flags (head_flags),
        .count      (fifo_count)
    );

    assign stat_rxrdy = (fifo_count != '0);
    assign stat_ffull = (fifo_count == CNT_W'(DEPTH));
    assign rd_data    = stat_rxrdy ? head_data : '0;
    assign stat_brk   = stat_rxrdy && head_flags.brk;
    assign stat_frm   = stat_rxrdy && head_flags.frm;
    assign stat_par   = stat_rxrdy && head_flags.par;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker (
    input logic clk,
    input logic rst,
    input logic rx_valid,
    input logic cpu_rd,
    input logic cmd_clr_err,
    input logic hold_valid,
    input logic in_brk,
    input logic stat_rxrdy,
    input logic stat_ffull,
    input logic stat_ovr,
    input logic irq_brk_chg
);
    // R5: a parked character implies the queue is full
    assert_park_only_when_full_R5: assert property (@(posedge clk) disable iff (rst)
        hold_valid |-> stat_ffull);

    // R4: reading while a character is parked keeps the queue full
    assert_full_kept_on_refill_R4: assert property (@(posedge clk) disable iff (rst)
        (hold_valid && cpu_rd) |=> stat_ffull);

    // R3: full implies ready
    assert_full_implies_ready_R3: assert property (@(posedge clk) disable iff (rst)
        stat_ffull |-> stat_rxrdy);

    // R7: overrun is sticky without a clear command
    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (stat_ovr && !cmd_clr_err) |=> stat_ovr);

    // R7: clear without a new arrival drops overrun
    assert_ovr_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_clr_err && !rx_valid) |=> !stat_ovr);

    // R10: each break state change is accompanied by a pulse
    assert_brk_edge_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        ($rose(in_brk) || $fell(in_brk)) |-> irq_brk_chg);

    // R10: no pulse without a break state change
    assert_brk_pulse_cause_R10: assert property (@(posedge clk) disable iff (rst)
        irq_brk_chg |-> ($rose(in_brk) || $fell(in_brk)));

    // R11: a read on an empty queue with no arrival leaves it empty
    assert_empty_read_R11: assert property (@(posedge clk) disable iff (rst)
        (!stat_rxrdy && cpu_rd && !rx_valid) |=> !stat_rxrdy);
endmodule

bind rxq_status rxq_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_valid    (rx_valid),
    .cpu_rd      (cpu_rd),
    .cmd_clr_err (cmd_clr_err),
    .hold_valid  (hold_valid),
    .in_brk      (in_brk),
    .stat_rxrdy  (stat_rxrdy),
    .stat_ffull  (stat_ffull),
    .stat_ovr    (stat_ovr),
    .irq_brk_chg (irq_brk_chg)
);

// File: tb/rxq_status_tb.sv
`timescale 1ns/1ps
module rxq_status_tb;
    localparam int DEPTH  = 3;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rx_valid = 1'b0;
    logic [DATA_W-1:0] rx_data = '0;
    logic              rx_frm_err = 1'b0;
    logic              rx_par_bit = 1'b0;
    logic              rx_line_idle = 1'b0;
    logic              cpu_rd = 1'b0;
    logic              cmd_clr_err = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic stat_rxrdy, stat_ffull, stat_ovr, stat_brk, stat_frm, stat_par, irq_brk_chg;

    int    checks = 0;
    int    fails  = 0;
    string phase  = "R1";
    bit    finished = 1'b0;

    always #2 clk = ~clk;

    rxq_status #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_frm_err(rx_frm_err), .rx_par_bit(rx_par_bit), .rx_line_idle(rx_line_idle),
        .cpu_rd(cpu_rd), .cmd_clr_err(cmd_clr_err), .rd_data(rd_data),
        .stat_rxrdy(stat_rxrdy), .stat_ffull(stat_ffull), .stat_ovr(stat_ovr),
        .stat_brk(stat_brk), .stat_frm(stat_frm), .stat_par(stat_par),
        .irq_brk_chg(irq_brk_chg)
    );

    // Reference model: entry = {data, brk, frm, par}
    logic [DATA_W+2:0] m_q[$];
    logic [DATA_W+2:0] m_hold;
    bit m_hold_v, m_ovr, m_inbrk, m_evt;

    always @(posedge clk) begin
        if (rst) begin
            m_q.delete();
            m_hold_v = 0; m_ovr = 0; m_inbrk = 0; m_evt = 0;
        end else begin
            bit acc, brkc, set_ovr;
            logic [DATA_W+2:0] nw;
            brkc = rx_frm_err && (rx_data == 0);
            nw = {rx_data, brkc, rx_frm_err, rx_par_bit};
            m_evt = 0;
            acc = rx_valid;
            set_ovr = 0;
            if (m_inbrk) begin
                acc = 0;
                if (rx_line_idle) begin m_inbrk = 0; m_evt = 1; end
            end else if (rx_valid && brkc) begin
                m_inbrk = 1; m_evt = 1;
            end
            if (cpu_rd && m_q.size() > 0) void'(m_q.pop_front());
            if (m_hold_v && m_q.size() < DEPTH) begin m_q.push_back(m_hold); m_hold_v = 0; end
            if (acc) begin
                if (m_hold_v) begin set_ovr = 1; m_hold = nw; end
                else if (m_q.size() < DEPTH) m_q.push_back(nw);
                else begin m_hold = nw; m_hold_v = 1; end
            end
            m_ovr = set_ovr || (m_ovr && !cmd_clr_err);
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s): act=%0h exp=%0h at %0t", tag, phase, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [DATA_W+2:0] h;
            h = (m_q.size() > 0) ? m_q[0] : '0;
            chk("R3 rxrdy", 32'(stat_rxrdy), 32'(m_q.size() > 0));
            chk("R4 ffull", 32'(stat_ffull), 32'(m_q.size() == DEPTH));
            chk("R6 R7 ovr", 32'(stat_ovr), 32'(m_ovr));
            chk("R10 brk_chg", 32'(irq_brk_chg), 32'(m_evt));
            chk("R2 R5 data", 32'(rd_data), 32'(h[DATA_W+2:3]));
            chk("R9 brk flag", 32'(stat_brk), 32'(h[2]));
            chk("R8 frm flag", 32'(stat_frm), 32'(h[1]));
            chk("R8 par flag", 32'(stat_par), 32'(h[0]));
        end
    end

    task automatic step(bit v, logic [7:0] d, bit frm, bit par,
                        bit idle, bit rd, bit clr);
        rx_valid = v; rx_data = d; rx_frm_err = frm; rx_par_bit = par;
        rx_line_idle = idle; cpu_rd = rd; cmd_clr_err = clr;
        @(negedge clk);
    endtask

    task automatic push(logic [7:0] d, bit frm = 0, bit par = 0);
        step(1, d, frm, par, 0, 0, 0);
    endtask

    task automatic pop();
        step(0, 0, 0, 0, 0, 1, 0);
    endtask

    task automatic idle_cyc();
        step(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        phase = "R1";
        chk("R1 rxrdy", 32'(stat_rxrdy), 0);
        chk("R1 ovr", 32'(stat_ovr), 0);
        chk("R1 data", 32'(rd_data), 0);
        chk("R1 brk_chg", 32'(irq_brk_chg), 0);
        idle_cyc();

        phase = "R2";
        push(8'hA1); push(8'hB2);
        pop(); pop(); idle_cyc();

        phase = "R5";
        push(8'h10); push(8'h11); push(8'h12); push(8'h13);
        idle_cyc();
        step(1, 8'h14, 0, 1, 0, 1, 0);   // read while parked, new arrival parks
        pop(); pop(); pop(); pop(); idle_cyc();

        phase = "R6";
        push(8'h20); push(8'h21); push(8'h22); push(8'h23, 1, 0);
        push(8'h24, 0, 1);               // overrun: 0x23 lost
        idle_cyc();
        phase = "R7";
        step(0, 0, 0, 0, 0, 0, 1);       // clear
        push(8'h25);                     // overrun again
        step(1, 8'h26, 0, 0, 0, 0, 1);   // overrun on same edge as clear
        idle_cyc();
        step(0, 0, 0, 0, 0, 0, 1);
        repeat (5) pop();

        phase = "R8";
        push(8'h31, 1, 0); push(8'h32, 0, 1); push(8'h33, 1, 1);
        pop(); pop(); pop();

        phase = "R9";
        step(0, 0, 0, 0, 1, 0, 0);       // idle outside a break: no effect
        push(8'h00, 0, 1);               // zero data with stop bit: ordinary
        push(8'h00, 1, 0);               // break
        push(8'h00, 1, 0);               // dropped
        push(8'h41);                     // dropped
        step(1, 8'h42, 0, 0, 1, 0, 0);   // dropped, break ends
        push(8'h43);
        pop(); pop(); pop(); idle_cyc();

        phase = "R10";
        push(8'h00, 1, 1);
        idle_cyc();
        step(0, 0, 0, 0, 1, 0, 0);
        idle_cyc();
        pop();

        phase = "R11";
        pop(); pop(); idle_cyc();
        push(8'h55); pop(); idle_cyc();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 5000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog (%s): act=1 exp=0", phase);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule